// File: doc/BRIEF.md
# Chip-Select Configuration Register Bank

This block holds one configuration word for each external chip select. Software reaches the words through a plain register port with separate write and read strobes. Each word selects three things for its chip select: the bus cycle type, multiplexed or separate address/data, and the data bus width. The bank turns every stored word into decoded mode signals for the bus engine that drives the external cycles.

Writes are made legal before they are stored. A cycle type that the chip select cannot use leaves the old cycle type in place. The synchronous pipelined type always clears the multiplexed bit. The spare width code is stored as 32-bit. Every rejected or corrected field raises a sticky error flag.

The boot device width is not known until the board comes up. When the clock-lock input goes from high to low, two strap pins on the external address bus are loaded into the width field of chip select 0.

Top module: `cs_cfg_bank`

## Requirements
- R1: After reset all eight words read 0x0000, every chip select decodes as strobe style A, non-multiplexed, 8-bit, and `cfg_err_o` is 0.
- R2: A write stores `wdata_i` into the word selected by `addr_i`, changing only the bits that R4, R5, R7 and R9 name. A read strobe returns the selected word on `rdata_o`, with `rvalid_o` high for exactly the cycle after the strobe.
- R3: The cycle type is the code {bit15, bit14, bit8}. 000 is strobe style A (`cyc_type_o` code 0). 010 is strobe style B (code 1). 100 is host-port style (code 2). 001 is synchronous pipelined (code 3). Each chip select has a 2-bit slice of `cyc_type_o` at [2n+1:2n].
- R4: A write of code 100 to chip selects 0 to 3 keeps bits 15, 14 and 8 at their old values and sets the error flag. The other bits of that write are stored.
- R5: A write of any code other than 000, 010, 100 or 001 (that is, 011, 101, 110 or 111) keeps bits 15, 14 and 8 on any chip select and sets the error flag.
- R6: Bit 4 of a stored word drives `mux_o[n]`. A value of 1 means multiplexed address/data.
- R7: While the stored cycle type is synchronous pipelined, bit 4 is stored as 0 and `mux_o[n]` is 0. No error is raised for this.
- R8: The width is the code {bit2, bit0}. 00 is 8-bit (`bus_width_o` code 0), 01 is 16-bit (code 1) and 10 is 32-bit (code 2), in slice [2n+1:2n].
- R9: A width code of 11 is stored as 10 (32-bit) and sets the error flag.
- R10: On the first rising clock edge at which `lock_i` is low after having been high, bits 2 and 0 of word 0 are loaded from `ext_addr_i[7]` and `ext_addr_i[0]`. The pair 11 is loaded as 10 and sets the error flag. The other bits of word 0 keep their values.
- R11: `cfg_err_o` stays high once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 3 | Chip select index for the access |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| lock_i | input | 1 | Clock-lock status; its falling edge triggers the strap load |
| ext_addr_i | input | 8 | External address bus; bits 7 and 0 are the width straps |
| cyc_type_o | output | 16 | Decoded cycle type, 2 bits per chip select |
| mux_o | output | 8 | Multiplexed mode, 1 bit per chip select |
| bus_width_o | output | 16 | Decoded width, 2 bits per chip select |
| cfg_err_o | output | 1 | Sticky error flag for illegal configuration |

## Verification
The bench builds the bank with its default parameters: eight chip selects, with host-port style allowed from chip select 4 upward. It therefore tests both sides of the host-port boundary. For every chip select it writes all eight cycle-type codes, both multiplexed settings and all four width codes, and checks the stored word and the decoded outputs against a model of the legalization rules. The strap load is tested across all four pin pairs, with word 0 first configured away from its reset value, so the test shows that only the width bits move.

// File: rtl/cs_cfg_pkg.sv
package cs_cfg_pkg;
  localparam int unsigned REG_W = 16;
  // field positions decoded by the bus engine
  localparam int unsigned CT_B2 = 15;
  localparam int unsigned CT_B1 = 14;
  localparam int unsigned CT_B0 = 8;
  localparam int unsigned MUX_B = 4;
  localparam int unsigned BW_B1 = 2;
  localparam int unsigned BW_B0 = 0;

  typedef logic [REG_W-1:0] cfg_word_t;

  typedef enum logic [1:0] {
    CYC_STROBE_A = 2'd0,
    CYC_STROBE_B = 2'd1,
    CYC_HOST     = 2'd2,
    CYC_SYNC     = 2'd3
  } cyc_e;

  typedef enum logic [1:0] {
    BW_8    = 2'd0,
    BW_16   = 2'd1,
    BW_32   = 2'd2,
    BW_RSVD = 2'd3
  } bw_e;

  function automatic logic [2:0] ct_field(cfg_word_t v);
    return {v[CT_B2], v[CT_B1], v[CT_B0]};
  endfunction

  function automatic cyc_e ct_decode(logic [2:0] f);
    case (f)
      3'b010:  return CYC_STROBE_B;
      3'b100:  return CYC_HOST;
      3'b001:  return CYC_SYNC;
      default: return CYC_STROBE_A;
    endcase
  endfunction
endpackage

// File: rtl/cs_cfg_legalize.sv
module cs_cfg_legalize
  import cs_cfg_pkg::*;
#(
  parameter bit HOST_OK = 1'b0
) (
  input  cfg_word_t old_i,
  input  cfg_word_t req_i,
  output cfg_word_t val_o,
  output logic      err_o
);
  logic [2:0] req_ct;
  logic       ct_ok;
  logic       bw_bad;

  assign req_ct = ct_field(req_i);

  always_comb begin
    case (req_ct)
      3'b000, 3'b010, 3'b001: ct_ok = 1'b1;
      3'b100:                 ct_ok = HOST_OK;
      default:                ct_ok = 1'b0;
    endcase
  end

  assign bw_bad = req_i[BW_B1] & req_i[BW_B0];

  always_comb begin
    val_o = req_i;
    if (!ct_ok) begin
      val_o[CT_B2] = old_i[CT_B2];
      val_o[CT_B1] = old_i[CT_B1];
      val_o[CT_B0] = old_i[CT_B0];
    end
    // pipelined synchronous cycles cannot share address and data pins
    if (ct_field(val_o) == 3'b001) val_o[MUX_B] = 1'b0;
    if (bw_bad) val_o[BW_B0] = 1'b0;
  end

  assign err_o = ~ct_ok | bw_bad;
endmodule

// File: rtl/cs_cfg_slot.sv
module cs_cfg_slot
  import cs_cfg_pkg::*;
#(
  parameter bit HOST_OK  = 1'b0,
  parameter bit STRAP_EN = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  cfg_word_t  wdata_i,
  input  logic       strap_i,
  input  logic [1:0] strap_bits_i,  // {width hi, width lo}
  output cfg_word_t  q_o,
  output logic       err_o,
  output cyc_e       cyc_o,
  output logic       mux_o,
  output bw_e        bw_o
);
  cfg_word_t q, nxt, leg_val;
  logic      leg_err;
  logic      strap_hit, strap_bad;
  logic [1:0] strap_w;

  cs_cfg_legalize #(.HOST_OK(HOST_OK)) u_leg (
    .old_i (q),
    .req_i (wdata_i),
    .val_o (leg_val),
    .err_o (leg_err)
  );

  if (STRAP_EN) begin : g_strap
    assign strap_hit = strap_i;
    assign strap_bad = &strap_bits_i;
    assign strap_w   = {strap_bits_i[1], strap_bits_i[0] & ~strap_bits_i[1]};
  end else begin : g_nostrap
    logic unused_strap;
    assign unused_strap = strap_i ^ (^strap_bits_i);
    assign strap_hit = 1'b0;
    assign strap_bad = 1'b0;
    assign strap_w   = 2'b00;
  end

  always_comb begin
    nxt   = q;
    err_o = 1'b0;
    if (wr_i) begin
      nxt   = leg_val;
      err_o = leg_err;
    end
    // strap load wins over a write for the width bits only
    if (strap_hit) begin
      nxt[BW_B1] = strap_w[1];
      nxt[BW_B0] = strap_w[0];
      err_o      = err_o | strap_bad;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign q_o   = q;
  assign cyc_o = ct_decode(ct_field(q));
  assign mux_o = q[MUX_B];
  assign bw_o  = bw_e'({q[BW_B1], q[BW_B0]});

  // R4
  host_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HOST_OK |-> cyc_o != CYC_HOST);

  // R7
  sync_nomux_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_o == CYC_SYNC |-> !mux_o);

  // R9
  bw_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bw_o != BW_RSVD);

  // R5
  rsvd_ct_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (ct_field(wdata_i) inside {3'b011, 3'b101, 3'b110, 3'b111}))
      |=> ct_field(q_o) == $past(ct_field(q_o)));
endmodule

// File: rtl/cs_cfg_rdport.sv
module cs_cfg_rdport #(
  parameter int unsigned NUM = 8,
  parameter int unsigned W   = 16,
  localparam int unsigned SEL_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rd_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic [NUM-1:0][W-1:0] words_i,
  output logic [W-1:0]          rdata_o,
  output logic                  rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= words_i[sel_i];
    end
  end
endmodule

// File: rtl/cs_cfg_bank.sv
module cs_cfg_bank
  import cs_cfg_pkg::*;
#(
  parameter int unsigned NUM_CS        = 8,
  parameter int unsigned HOST_FIRST_CS = 4,
  parameter int unsigned EXT_ADDR_W    = 8,
  parameter int unsigned STRAP_LO_BIT  = 0,
  parameter int unsigned STRAP_HI_BIT  = 7,
  localparam int unsigned CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [CS_W-1:0]       addr_i,
  input  logic [REG_W-1:0]      wdata_i,
  output logic [REG_W-1:0]      rdata_o,
  output logic                  rvalid_o,
  input  logic                  lock_i,
  input  logic [EXT_ADDR_W-1:0] ext_addr_i,
  output logic [2*NUM_CS-1:0]   cyc_type_o,
  output logic [NUM_CS-1:0]     mux_o,
  output logic [2*NUM_CS-1:0]   bus_width_o,
  output logic                  cfg_err_o
);
  logic [NUM_CS-1:0][REG_W-1:0] cfg_q;
  logic [NUM_CS-1:0]            slot_err;
  logic                         lock_q, strap_fire, err_q;
  logic [1:0]                   strap_bits;
  logic                         unused_addr;

  assign strap_bits  = {ext_addr_i[STRAP_HI_BIT], ext_addr_i[STRAP_LO_BIT]};
  assign unused_addr = ^ext_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else         lock_q <= lock_i;
  end
  assign strap_fire = lock_q & ~lock_i;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    cyc_e cyc;
    bw_e  bw;
    cs_cfg_slot #(
      .HOST_OK  (g >= HOST_FIRST_CS),
      .STRAP_EN (g == 0)
    ) u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_i         (wr_en_i && (addr_i == CS_W'(g))),
      .wdata_i      (wdata_i),
      .strap_i      (strap_fire),
      .strap_bits_i (strap_bits),
      .q_o          (cfg_q[g]),
      .err_o        (slot_err[g]),
      .cyc_o        (cyc),
      .mux_o        (mux_o[g]),
      .bw_o         (bw)
    );
    assign cyc_type_o[2*g +: 2]  = cyc;
    assign bus_width_o[2*g +: 2] = bw;
  end

  cs_cfg_rdport #(.NUM(NUM_CS), .W(REG_W)) u_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd_en_i),
    .sel_i    (addr_i),
    .words_i  (cfg_q),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (|slot_err) err_q <= 1'b1;
  end
  assign cfg_err_o = err_q;

  // R2
  rvalid_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);

  // R2
  rvalid_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o);

  // R11
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);

  // R10
  strap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !lock_i) |=>
      (cfg_q[0][BW_B1] == $past(ext_addr_i[STRAP_HI_BIT])) &&
      (cfg_q[0][BW_B0] == ($past(ext_addr_i[STRAP_LO_BIT]) && !$past(ext_addr_i[STRAP_HI_BIT]))));
endmodule

// File: tb/sim_cs_cfg_bank.sv
`timescale 1ns/1ps
module sim_cs_cfg_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, lock = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [7:0]  ext_addr = '0;
  logic [15:0] rdata;
  logic        rvalid, err;
  logic [15:0] cyc_type, bus_width;
  logic [7:0]  mux;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] model [8];
  logic        exp_err;

  always #2 clk = ~clk;  // 250 MHz

  cs_cfg_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .lock_i(lock), .ext_addr_i(ext_addr), .cyc_type_o(cyc_type),
    .mux_o(mux), .bus_width_o(bus_width), .cfg_err_o(err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] legal(int cs, logic [15:0] old, logic [15:0] w);
    logic [15:0] v;
    logic        e;
    logic [2:0]  t;
    logic        ok;
    v = w; e = 1'b0; t = {w[15], w[14], w[8]};
    ok = (t == 3'b000) || (t == 3'b010) || (t == 3'b001) || (t == 3'b100 && cs >= 4);
    if (!ok) begin v[15] = old[15]; v[14] = old[14]; v[8] = old[8]; e = 1'b1; end
    if ({v[15], v[14], v[8]} == 3'b001) v[4] = 1'b0;
    if (v[2] && v[0]) begin v[0] = 1'b0; e = 1'b1; end
    return {e, v};
  endfunction

  function automatic logic [1:0] ct_code(logic [15:0] v);
    case ({v[15], v[14], v[8]})
      3'b010:  return 2'd1;
      3'b100:  return 2'd2;
      3'b001:  return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  task automatic do_write(int cs, logic [15:0] w);
    logic [16:0] r;
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(cs); wdata = w;
    @(negedge clk);
    wr_en = 1'b0;
    r = legal(cs, model[cs], w);
    model[cs] = r[15:0];
    exp_err = exp_err | r[16];
  endtask

  task automatic do_read(int cs, string req);
    @(negedge clk);
    rd_en = 1'b1; addr = 3'(cs);
    @(negedge clk);
    rd_en = 1'b0;
    check(req, {31'd0, rvalid}, 32'd1);
    check(req, {16'd0, rdata}, {16'd0, model[cs]});
  endtask

  task automatic check_outs(int cs);
    check("R3",  {30'd0, cyc_type[2*cs +: 2]}, {30'd0, ct_code(model[cs])});
    check("R6",  {31'd0, mux[cs]}, {31'd0, model[cs][4]});
    check("R8",  {30'd0, bus_width[2*cs +: 2]}, {30'd0, model[cs][2], model[cs][0]});
    check("R11", {31'd0, err}, {31'd0, exp_err});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; lock = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) model[i] = '0;
    exp_err = 1'b0;
  endtask

  task automatic strap(logic a7, logic a0);
    @(negedge clk);
    lock = 1'b1; ext_addr = 8'h5a;  // middle bits must not matter
    @(negedge clk);
    check("R10", {30'd0, bus_width[1:0]}, {30'd0, model[0][2], model[0][0]});
    ext_addr = {a7, 6'b101101, a0};
    lock = 1'b0;
    @(negedge clk);
    model[0][2] = a7;
    model[0][0] = a0 & ~a7;
    exp_err = exp_err | (a7 & a0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    exp_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", {31'd0, rvalid}, 32'd0);
    check("R1", {16'd0, cyc_type}, 32'd0);
    check("R1", {16'd0, bus_width}, 32'd0);
    check("R1", {24'd0, mux}, 32'd0);
    check("R1", {31'd0, err}, 32'd0);
    for (int cs = 0; cs < 8; cs++) do_read(cs, "R1");
    @(negedge clk);
    check("R2", {31'd0, rvalid}, 32'd0);

    // sweep: every chip select, type code, mux bit and width code
    for (int cs = 0; cs < 8; cs++) begin
      for (int t = 0; t < 8; t++) begin
        for (int m = 0; m < 2; m++) begin
          for (int b = 0; b < 4; b++) begin
            logic [15:0] w;
            logic [2:0]  tv;
            logic [1:0]  bv;
            string       tag;
            tv = 3'(t); bv = 2'(b);
            w = '0;
            w[13:9] = 5'(cs * 3 + t);
            w[7:5]  = 3'(b + cs);
            w[3]    = 1'(m) ^ 1'(cs);
            w[1]    = tv[0] ^ bv[0];
            w[15] = tv[2]; w[14] = tv[1]; w[8] = tv[0];
            w[4] = 1'(m); w[2] = bv[1]; w[0] = bv[0];
            if (tv == 3'b100 && cs < 4) tag = "R4";
            else if (!(tv inside {3'b000, 3'b010, 3'b001, 3'b100})) tag = "R5";
            else if (tv == 3'b001 && m == 1) tag = "R7";
            else if (bv == 2'b11) tag = "R9";
            else tag = "R2";
            do_write(cs, w);
            check_outs(cs);
            do_read(cs, tag);
          end
        end
      end
    end

    // R10 strap load on clock-lock fall, other bits of word 0 preserved
    do_reset();
    do_write(0, 16'h4a1a);  // strobe B, multiplexed, width 8, stray bits
    check_outs(0);
    strap(1'b0, 1'b1);
    check_outs(0);
    do_read(0, "R10");
    strap(1'b1, 1'b0);
    check_outs(0);
    do_read(0, "R10");
    strap(1'b0, 1'b0);
    check_outs(0);
    do_read(0, "R10");
    check("R10", {31'd0, err}, 32'd0);
    strap(1'b1, 1'b1);
    check_outs(0);
    do_read(0, "R10");
    check("R10", {31'd0, err}, 32'd1);
    repeat (3) @(negedge clk);
    check("R11", {31'd0, err}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule